// File: doc/BRIEF.md
# Multiplexed ADC Conversion Controller

This block is the register-side controller for a ten-input analog-to-digital converter. Software writes one control word that names the input to convert, carries a one-hot enable for that input, can ask for an extra settling interval and sets a start bit. The block then runs the conversion and raises a completion flag in a status register. An interrupt-enable register turns that flag into a level interrupt. The result is read from a data register.

The real converter is replaced by a behavioural stub. It takes a signed sample of each of the eight external inputs when the conversion is accepted. After a fixed, parameterised number of clock cycles it delivers that sample in offset-binary form. The two remaining inputs are internal references: one sits at full positive scale and one at zero.

Registers, selected by `regAddr`: 0 = control (reads as zero), 1 = status, 2 = interrupt enable, 3 = result. Writes take effect at the rising clock edge while `wrEn` is high. Reads are combinational.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset the status, interrupt-enable and result registers all read 0x0000, and `irq` is low.
- R2: A write to the control register with bit 0 set starts a conversion of the input whose index is in bits 4:1, but only if that input's enable bit, bit (5 + index) of the same word, is set. Otherwise the write is ignored: status bit 0 (busy) stays 0 and no completion follows.
- R3: An accepted start makes status bit 0 read 1 for exactly LAT cycles when control bit 15 is clear, or LAT+DLY cycles when it is set. At the end of that window busy returns to 0 and status bit 2 (done) reads 1.
- R4: The result register returns the selected input's two's-complement sample, taken at the start edge, with bit 15 inverted. Input 8 returns 0xFFFF, input 9 returns 0x8000, and the result register changes only when a conversion completes.
- R5: Writing the status register with bit 2 set clears the done flag. Writing it with bit 2 clear leaves the flag unchanged.
- R6: A start written while a conversion is busy is ignored. The running conversion keeps its input and its completion time.
- R7: Interrupt-enable bit 2 is stored and reads back. `irq` is high exactly while both the done flag and that bit are 1, and it stays high until one of them is cleared.
- R8: If a done-clearing status write lands on the same edge as a conversion completion, the flag ends up set.
- R9: A start whose index field is 10 or more is ignored, even with every enable bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select (0 control, 1 status, 2 interrupt enable, 3 result) |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for the register at `regAddr` |
| sampleIn | input | 128 | Eight signed 16-bit samples; input i occupies bits 16i+15:16i |
| irq | output | 1 | Level interrupt: done flag AND enable |

## Verification
Two events can meet on one edge: a conversion completing, which sets the done flag, and a software write that clears it. The bench lines up the status write so that its edge is exactly the completion edge of a conversion started a known number of cycles earlier. A done flag that reads 1 afterwards shows that the set took priority. A separate case overlaps a new start with a busy conversion. It is judged by the unchanged completion cycle and by the result carrying the first input's value.

// File: rtl/adc_conv_pkg.sv
package adc_conv_pkg;
  localparam int WORD_W    = 16;
  localparam int CH_CNT    = 10;
  localparam int EXT_CH    = 8;
  localparam int SEL_W     = $clog2(CH_CNT);
  localparam int START_BIT = 0;
  localparam int SEL_LSB   = 1;
  localparam int EN_LSB    = 5;
  localparam int DELAY_BIT = 15;
  localparam int BUSY_BIT  = 0;
  localparam int DONE_BIT  = 2;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_IEN  = 2'd2;
  localparam logic [1:0] ADDR_DATA = 2'd3;

  typedef struct packed {
    logic             capture;
    logic [SEL_W-1:0] chan;
    logic             finish;
  } convStrobe_t;
endpackage

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_conv_pkg::*;
#(
  parameter int LAT = 6,
  parameter int DLY = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrlWr,
  input  logic [WORD_W-1:0] ctrlWord,
  output logic              busy,
  output convStrobe_t       strobe
);
  localparam int MAXCYC = LAT + DLY;
  localparam int CNT_W  = $clog2(MAXCYC + 1);

  logic [CNT_W-1:0]  cnt;
  logic [SEL_W-1:0]  selIdx;
  logic [CH_CNT-1:0] enField;
  logic              chanOk;
  logic              accept;
  logic [CNT_W-1:0]  loadVal;

  assign selIdx  = ctrlWord[SEL_LSB +: SEL_W];
  assign enField = ctrlWord[EN_LSB +: CH_CNT];

  always_comb begin
    chanOk = 1'b0;
    for (int i = 0; i < CH_CNT; i++) begin
      if (selIdx == SEL_W'(i) && enField[i]) chanOk = 1'b1;
    end
  end

  assign accept  = ctrlWr && ctrlWord[START_BIT] && !busy && chanOk;
  assign loadVal = ctrlWord[DELAY_BIT] ? CNT_W'(MAXCYC - 1) : CNT_W'(LAT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= loadVal;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign strobe.capture = accept;
  assign strobe.chan    = selIdx;
  assign strobe.finish  = busy && (cnt == '0);
endmodule

// File: rtl/adc_conv_dp.sv
module adc_conv_dp
  import adc_conv_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  convStrobe_t              strobe,
  input  logic [EXT_CH*WORD_W-1:0] sampleIn,
  input  logic                     statWr,
  input  logic                     ienWr,
  input  logic [WORD_W-1:0]        wrData,
  output logic                     doneFlag,
  output logic                     ienBit,
  output logic [WORD_W-1:0]        resultWord
);
  localparam logic [WORD_W-1:0] REF_HI  = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] REF_LO  = '0;
  localparam logic [WORD_W-1:0] MSB_FLIP = {1'b1, {(WORD_W-1){1'b0}}};

  logic [WORD_W-1:0] picked;
  logic [WORD_W-1:0] holdWord;

  always_comb begin
    picked = REF_LO;
    for (int i = 0; i < EXT_CH; i++) begin
      if (strobe.chan == SEL_W'(i)) picked = sampleIn[i*WORD_W +: WORD_W];
    end
    if (strobe.chan == SEL_W'(EXT_CH)) picked = REF_HI;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdWord   <= '0;
      resultWord <= '0;
      doneFlag   <= 1'b0;
      ienBit     <= 1'b0;
    end else begin
      if (strobe.capture) holdWord <= picked ^ MSB_FLIP;
      if (strobe.finish) resultWord <= holdWord;
      if (strobe.finish)                     doneFlag <= 1'b1;
      else if (statWr && wrData[DONE_BIT])   doneFlag <= 1'b0;
      if (ienWr) ienBit <= wrData[DONE_BIT];
    end
  end
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_conv_pkg::*;
#(
  parameter int LAT = 6,
  parameter int DLY = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wrEn,
  input  logic [1:0]               regAddr,
  input  logic [WORD_W-1:0]        wrData,
  output logic [WORD_W-1:0]        rdData,
  input  logic [EXT_CH*WORD_W-1:0] sampleIn,
  output logic                     irq
);
  convStrobe_t       strobeW;
  logic              busyW;
  logic              doneW;
  logic              ienW;
  logic [WORD_W-1:0] resultW;

  adc_conv_seq #(.LAT(LAT), .DLY(DLY)) uSeq (
    .clk(clk), .rst(rst),
    .ctrlWr(wrEn && regAddr == ADDR_CTRL),
    .ctrlWord(wrData),
    .busy(busyW),
    .strobe(strobeW)
  );

  adc_conv_dp uDp (
    .clk(clk), .rst(rst),
    .strobe(strobeW),
    .sampleIn(sampleIn),
    .statWr(wrEn && regAddr == ADDR_STAT),
    .ienWr(wrEn && regAddr == ADDR_IEN),
    .wrData(wrData),
    .doneFlag(doneW),
    .ienBit(ienW),
    .resultWord(resultW)
  );

  always_comb begin
    rdData = '0;
    case (regAddr)
      ADDR_STAT: begin
        rdData[BUSY_BIT] = busyW;
        rdData[DONE_BIT] = doneW;
      end
      ADDR_IEN:  rdData[DONE_BIT] = ienW;
      ADDR_DATA: rdData = resultW;
      default:   rdData = '0;
    endcase
  end

  assign irq = doneW && ienW;
endmodule

// File: rtl/adc_conv_chk.sv
module adc_conv_chk
  import adc_conv_pkg::*;
#(
  parameter int LAT = 6,
  parameter int DLY = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [1:0]        regAddr,
  input logic [WORD_W-1:0] wrData,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] result,
  input logic              irq
);
  localparam int RUN_W = $clog2(LAT + DLY + 2);
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (rst)       busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  assert_start_source_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wrEn && regAddr == ADDR_CTRL && wrData[START_BIT]));

  assert_busy_bound_R3: assert property (@(posedge clk) disable iff (rst)
    busyRun <= RUN_W'(LAT + DLY));

  assert_done_at_end_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(busy));

  assert_result_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy) |-> $stable(result));

  assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
    (wrEn && regAddr == ADDR_STAT && wrData[DONE_BIT]) |=> (!done || $fell(busy)));

  assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
    (irq && !(wrEn && (regAddr == ADDR_STAT || regAddr == ADDR_IEN))) |=> irq);
endmodule

bind adc_conv_ctrl adc_conv_chk #(.LAT(LAT), .DLY(DLY)) uChk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
  .busy(busyW), .done(doneW), .result(resultW), .irq(irq)
);

// File: tb/sim_adc_conv_ctrl.sv
module sim_adc_conv_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 6;
  localparam int DLY = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wrEn = 1'b0;
  logic [1:0]   regAddr = 2'd0;
  logic [15:0]  wrData = 16'd0;
  logic [15:0]  rdData;
  logic [127:0] sampleIn = '0;
  logic         irq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  adc_conv_ctrl #(.LAT(LAT), .DLY(DLY)) u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .sampleIn(sampleIn), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  function automatic logic [15:0] sampleVal(input int ch, input int gen);
    return 16'((ch + 1) * 16'h2345 + gen * 16'h1111 + 16'h0421);
  endfunction

  function automatic logic [15:0] expResult(input int ch, input int gen);
    if (ch == 8) return 16'hFFFF;
    if (ch == 9) return 16'h8000;
    return sampleVal(ch, gen) ^ 16'h8000;
  endfunction

  task automatic loadSamples(input int gen);
    for (int i = 0; i < 8; i++) sampleIn[i*16 +: 16] = sampleVal(i, gen);
  endtask

  function automatic logic [15:0] ctrlWord(input int ch, input bit dly);
    logic [15:0] w;
    w = 16'h0001 | 16'(ch << 1) | 16'(1 << (5 + ch));
    if (dly) w[15] = 1'b1;
    return w;
  endfunction

  // One full conversion: R3 timing, R4 result, R5 clear
  task automatic runConv(input int ch, input bit dly, input int gen);
    logic [15:0] d;
    int total;
    total = dly ? LAT + DLY : LAT;
    loadSamples(gen);
    wr(2'd0, ctrlWord(ch, dly));
    loadSamples(gen + 1);
    repeat (total - 1) @(negedge clk);
    rd(2'd1, d);
    chk(d == 16'h0001, "R3 busy before end", d, 16'h0001);
    @(negedge clk);
    rd(2'd1, d);
    chk(d == 16'h0004, "R3 done at end", d, 16'h0004);
    rd(2'd3, d);
    chk(d == expResult(ch, gen), "R4 result", d, expResult(ch, gen));
    wr(2'd1, 16'h0004);
    rd(2'd1, d);
    chk(d == 16'h0000, "R5 w1c clear", d, 16'h0000);
  endtask

  initial begin
    logic [15:0] d;
    loadSamples(0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    rd(2'd1, d); chk(d == 16'h0000, "R1 status", d, 16'h0000);
    rd(2'd2, d); chk(d == 16'h0000, "R1 ien", d, 16'h0000);
    rd(2'd3, d); chk(d == 16'h0000, "R1 result", d, 16'h0000);
    chk(irq == 1'b0, "R1 irq", 16'(irq), 16'h0000);

    // sweep every input with and without settling delay
    for (int ch = 0; ch < 10; ch++) begin
      for (int dl = 0; dl < 2; dl++) runConv(ch, dl[0], ch * 2 + dl);
    end

    // R2: input 3 selected but only input 4 enabled
    wr(2'd0, 16'h0001 | 16'(3 << 1) | 16'(1 << 9));
    rd(2'd1, d); chk(d == 16'h0000, "R2 disabled input ignored", d, 16'h0000);
    repeat (LAT + 2) @(negedge clk);
    rd(2'd1, d); chk(d == 16'h0000, "R2 no completion", d, 16'h0000);

    // R9: index 12 with every enable set
    wr(2'd0, 16'h7FE1 | 16'(12 << 1));
    rd(2'd1, d); chk(d == 16'h0000, "R9 out of range index", d, 16'h0000);
    // start bit clear: nothing happens (R2)
    wr(2'd0, ctrlWord(1, 1'b0) & 16'hFFFE);
    rd(2'd1, d); chk(d == 16'h0000, "R2 no start bit", d, 16'h0000);

    // R5: writing zero does not clear
    loadSamples(40);
    wr(2'd0, ctrlWord(6, 1'b0));
    repeat (LAT) @(negedge clk);
    wr(2'd1, 16'hFFFB);
    rd(2'd1, d); chk(d == 16'h0004, "R5 zero write keeps done", d, 16'h0004);

    // R7: interrupt enable and level hold
    chk(irq == 1'b0, "R7 irq off without enable", 16'(irq), 16'h0000);
    wr(2'd2, 16'h0004);
    rd(2'd2, d); chk(d == 16'h0004, "R7 ien readback", d, 16'h0004);
    chk(irq == 1'b1, "R7 irq on", 16'(irq), 16'h0001);
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R7 irq held", 16'(irq), 16'h0001);
    wr(2'd1, 16'h0004);
    chk(irq == 1'b0, "R7 irq cleared with done", 16'(irq), 16'h0000);

    // R6: start while busy is ignored
    loadSamples(50);
    wr(2'd0, ctrlWord(2, 1'b0));
    repeat (2) @(negedge clk);
    wr(2'd0, ctrlWord(5, 1'b1));
    @(negedge clk);
    rd(2'd1, d); chk(d == 16'h0001, "R6 still busy", d, 16'h0001);
    @(negedge clk);
    rd(2'd1, d); chk(d == 16'h0004, "R6 original finish time", d, 16'h0004);
    chk(irq == 1'b1, "R7 irq on completion", 16'(irq), 16'h0001);
    rd(2'd3, d); chk(d == expResult(2, 50), "R6 original input kept", d, expResult(2, 50));
    repeat (3) @(negedge clk);
    rd(2'd1, d); chk(d == 16'h0004, "R6 no restart", d, 16'h0004);

    // R8: clear write on the completion edge
    loadSamples(60);
    wr(2'd0, ctrlWord(7, 1'b0));
    repeat (LAT - 2) @(negedge clk);
    wr(2'd1, 16'h0004);
    rd(2'd1, d); chk(d == 16'h0004, "R8 set wins over clear", d, 16'h0004);
    rd(2'd3, d); chk(d == expResult(7, 60), "R8 result", d, expResult(7, 60));
    wr(2'd2, 16'h0000);
    chk(irq == 1'b0, "R7 irq off when enable cleared", 16'(irq), 16'h0000);
    wr(2'd1, 16'h0004);
    rd(2'd1, d); chk(d == 16'h0000, "R5 clear after R8", d, 16'h0000);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0000, 16'h0001);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule